// File: doc/BRIEF.md
# Split/Joined Timer-Counter with Capture

This block holds two 8-bit count halves that software can run apart or chain into a single 16-bit count. A shared programmable prescaler supplies the timing tick; an external event line, passed through a two-flop synchronizer and a rising-edge detector, supplies the counting tick. A two-bit mode field picks one of four arrangements:
- **Mode 0:** two prescaled 8-bit timers.
- **Mode 1:** a prescaled 8-bit timer in the low half and an 8-bit event counter in the high half.
- **Mode 2:** a joined 16-bit prescaled timer.
- **Mode 3:** a joined 16-bit event counter.

Each running count is compared against a match value. On a tick while the count equals its match value, the count returns to zero and an interrupt flag is raised. Two capture strobes copy the live count into read-back registers. In the joined modes, either strobe copies both bytes in the same clock, so software never reads a torn 16-bit value.

Configuration arrives over a small write-only register port. Counts, captures and flags are visible as plain outputs.

Top module: `tmr_dual_capture`

## Requirements
- R1: After reset, both counts, both capture registers and both flags are zero, the mode is 0 and counting is stopped.
- R2: While running, a prescaler value N makes each prescaled count advance once every N+1 clocks. The prescaler restarts from zero whenever counting is stopped.
- R3: In mode 0 the two halves count prescaler ticks independently. Each half has its own match value and its own flag: flag bit 0 belongs to the low half and bit 1 to the high half.
- R4: A tick that arrives while a count equals its match value loads zero instead of incrementing and sets that half's flag. A match value M therefore gives a period of M+1 ticks.
- R5: In mode 1 the low half is a prescaled timer and the high half counts event edges. The high half uses its own match value and flag bit 1.
- R6: The event input passes through two synchronizing flops and an edge detector. A low-to-high change that is first sampled at clock edge k increments the event count at edge k+2. A pulse that is one clock high and one clock low is counted.
- R7: In mode 2 the halves form one 16-bit prescaled timer. The low byte carries into the high byte. The 16-bit match value is {high match, low match}, and a 16-bit match sets flag bit 1 only.
- R8: In mode 3 the halves form one 16-bit event counter. The prescaler setting has no effect on it. The match and flag behave as in R7.
- R9: In modes 0 and 1, the low strobe copies the low count into the low capture register, and the high strobe copies the high count into the high capture register. Each copy takes the count value from before that clock's update.
- R10: In modes 2 and 3, either strobe copies both count bytes into both capture registers in the same clock.
- R11: Writing to address 4 clears each flag whose data bit is 1. A flag set in the same clock as its clear stays set. The interrupt output is high whenever either flag is set.
- R12: A control write that changes the mode zeroes both counts and the prescaler in that clock. While counting is stopped, the counts hold.
- R13: Writes are decoded by address as follows: 0 = control (bits 1:0 mode, bit 2 run), 1 = prescaler value, 2 = low match, 3 = high match, 4 = flag clear. A written value takes effect from the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | HALF_W | Register write data |
| evt_i | input | 1 | Asynchronous external event line |
| cap_lo_i | input | 1 | Low capture strobe |
| cap_hi_i | input | 1 | High capture strobe |
| cnt_lo_o | output | HALF_W | Low count |
| cnt_hi_o | output | HALF_W | High count |
| cap_lo_o | output | HALF_W | Low capture register |
| cap_hi_o | output | HALF_W | High capture register |
| flag_o | output | 2 | Match flags (bit 0 low half, bit 1 high half or joined count) |
| irq_o | output | 1 | OR of the flags |

## Verification
Two events can land in one clock: a capture strobe can coincide with a count update, and a flag clear can coincide with the match that sets the same flag. The bench provokes the first by driving pseudo-random strobes while the counts advance on every clock or on random event edges. It judges each capture against the count value from before the edge. It provokes the second by writing the clear on every clock while a short match period keeps raising the flag. The bench's reference model, which applies the clear before the set, must see the flag survive in exactly the clocks where a match occurs.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   typedef enum logic [1:0] {
      MODE_SPLIT    = 2'd0,
      MODE_TMR_EVT  = 2'd1,
      MODE_JOIN_TMR = 2'd2,
      MODE_JOIN_EVT = 2'd3
   } tmr_mode_e;

   localparam int ADDR_W = 3;

   localparam logic [ADDR_W-1:0] ADDR_CTRL  = 3'd0;
   localparam logic [ADDR_W-1:0] ADDR_PRE   = 3'd1;
   localparam logic [ADDR_W-1:0] ADDR_MLO   = 3'd2;
   localparam logic [ADDR_W-1:0] ADDR_MHI   = 3'd3;
   localparam logic [ADDR_W-1:0] ADDR_FCLR  = 3'd4;

   localparam int CTRL_RUN_BIT = 2;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int PRE_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             run_i,
   input  logic [PRE_W-1:0] div_i,
   output logic             tick_o
);

   logic [PRE_W-1:0] cnt_q;
   logic             at_end;

   assign at_end = (cnt_q == div_i);
   assign tick_o = run_i & at_end;

   // A value of N divides by N+1; a stopped prescaler restarts from zero.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         cnt_q <= '0;
      else if (clr_i || !run_i || at_end)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/tmr_evt_sync.sv
module tmr_evt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic evt_i,
   output logic rise_o
);

   localparam int LAST = STAGES;

   logic [LAST:0] sh_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         sh_q <= '0;
      else
         sh_q <= {sh_q[LAST-1:0], evt_i};
   end

   // Stages 0..STAGES-1 synchronize; the last flop keeps the previous level.
   assign rise_o = sh_q[LAST-1] & ~sh_q[LAST];

endmodule

// File: rtl/tmr_half.sv
module tmr_half #(
   parameter int W = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         clr_i,
   input  logic         tick_i,
   input  logic         wrap_i,
   input  logic [W-1:0] match_i,
   output logic [W-1:0] cnt_o,
   output logic         hit_o,
   output logic         ones_o
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         cnt_q <= '0;
      else if (clr_i || wrap_i)
         cnt_q <= '0;
      else if (tick_i)
         cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o  = cnt_q;
   assign hit_o  = (cnt_q == match_i);
   assign ones_o = &cnt_q;

endmodule

// File: rtl/tmr_dual_capture.sv
module tmr_dual_capture
   import tmr_pkg::*;
#(
   parameter int HALF_W      = 8,
   parameter int PRE_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [HALF_W-1:0] wr_data_i,
   input  logic              evt_i,
   input  logic              cap_lo_i,
   input  logic              cap_hi_i,
   output logic [HALF_W-1:0] cnt_lo_o,
   output logic [HALF_W-1:0] cnt_hi_o,
   output logic [HALF_W-1:0] cap_lo_o,
   output logic [HALF_W-1:0] cap_hi_o,
   output logic [1:0]        flag_o,
   output logic              irq_o
);

   localparam int NHALF  = 2;
   localparam int FULL_W = NHALF * HALF_W;

   generate
      if (HALF_W < CTRL_RUN_BIT + 1) begin : g_bad_half_w
         $error("HALF_W too narrow for the control field");
      end
      if (PRE_W < 1 || PRE_W > HALF_W) begin : g_bad_pre_w
         $error("PRE_W must lie in 1..HALF_W");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   // ---------------- configuration registers ----------------
   tmr_mode_e                       mode_q;
   logic                            run_q;
   logic [PRE_W-1:0]                pre_q;
   logic [NHALF-1:0][HALF_W-1:0]    match_q;
   logic                            wr_ctrl;
   logic                            wr_fclr;
   logic                            clr;
   tmr_mode_e                       mode_new;

   assign mode_new = tmr_mode_e'(wr_data_i[1:0]);
   assign wr_ctrl  = wr_en_i && (wr_addr_i == ADDR_CTRL);
   assign wr_fclr  = wr_en_i && (wr_addr_i == ADDR_FCLR);
   assign clr      = wr_ctrl && (mode_new != mode_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mode_q  <= MODE_SPLIT;
         run_q   <= 1'b0;
         pre_q   <= '0;
         match_q <= '0;
      end else if (wr_en_i) begin
         case (wr_addr_i)
            ADDR_CTRL: begin
               mode_q <= mode_new;
               run_q  <= wr_data_i[CTRL_RUN_BIT];
            end
            ADDR_PRE: pre_q      <= wr_data_i[PRE_W-1:0];
            ADDR_MLO: match_q[0] <= wr_data_i;
            ADDR_MHI: match_q[1] <= wr_data_i;
            default: ;
         endcase
      end
   end

   // ---------------- tick sources ----------------
   logic pre_tick;
   logic evt_rise;
   logic evt_tick;

   tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr),
      .run_i  (run_q),
      .div_i  (pre_q),
      .tick_o (pre_tick)
   );

   tmr_evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .evt_i  (evt_i),
      .rise_o (evt_rise)
   );

   assign evt_tick = run_q & evt_rise;

   logic [NHALF-1:0] src;
   logic             joined;

   assign joined = (mode_q == MODE_JOIN_TMR) || (mode_q == MODE_JOIN_EVT);

   always_comb begin
      unique case (mode_q)
         MODE_SPLIT:    src = {pre_tick, pre_tick};
         MODE_TMR_EVT:  src = {evt_tick, pre_tick};
         MODE_JOIN_TMR: src = {pre_tick, pre_tick};
         MODE_JOIN_EVT: src = {evt_tick, evt_tick};
         default:       src = '0;
      endcase
   end

   // ---------------- halves, chaining and match ----------------
   logic [NHALF-1:0][HALF_W-1:0] cnt;
   logic [NHALF-1:0]             hit;
   logic [NHALF-1:0]             ones;
   logic [NHALF-1:0]             tick;
   logic [NHALF-1:0]             wrap;
   logic [1:0]                   fset;
   logic                         full_hit;

   assign full_hit = &hit;

   always_comb begin
      if (joined) begin
         tick[0] = src[0];
         tick[1] = src[0] & ones[0];
         wrap    = {NHALF{src[0] & full_hit}};
         fset    = {src[0] & full_hit & ~clr, 1'b0};
      end else begin
         tick    = src;
         wrap    = src & hit;
         fset    = wrap & {NHALF{~clr}};
      end
   end

   logic [NHALF-1:0]             strobe;
   logic [NHALF-1:0][HALF_W-1:0] cap_q;

   assign strobe = {cap_hi_i, cap_lo_i};

   for (genvar h = 0; h < NHALF; h++) begin : g_half
      logic load;

      tmr_half #(.W(HALF_W)) u_half (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .clr_i   (clr),
         .tick_i  (tick[h]),
         .wrap_i  (wrap[h]),
         .match_i (match_q[h]),
         .cnt_o   (cnt[h]),
         .hit_o   (hit[h]),
         .ones_o  (ones[h])
      );

      // Joined modes load every byte from either strobe for a coherent copy.
      assign load = joined ? (|strobe) : strobe[h];

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)
            cap_q[h] <= '0;
         else if (load)
            cap_q[h] <= cnt[h];
      end
   end

   // ---------------- flags ----------------
   logic [1:0] flag_q;
   logic [1:0] fclr;

   assign fclr = wr_fclr ? wr_data_i[1:0] : 2'b00;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         flag_q <= 2'b00;
      else
         flag_q <= (flag_q & ~fclr) | fset;
   end

   logic [FULL_W-1:0] full_cnt;
   assign full_cnt = cnt;

   assign cnt_lo_o = full_cnt[HALF_W-1:0];
   assign cnt_hi_o = full_cnt[FULL_W-1:HALF_W];
   assign cap_lo_o = cap_q[0];
   assign cap_hi_o = cap_q[1];
   assign flag_o   = flag_q;
   assign irq_o    = |flag_q;

endmodule

// File: rtl/tmr_dual_capture_chk.sv
module tmr_dual_capture_chk #(
   parameter int W = 8
) (
   input logic         clk_i,
   input logic         rst_ni,
   input logic [1:0]   mode_i,
   input logic         run_i,
   input logic         clr_i,
   input logic         cap_lo_i,
   input logic         cap_hi_i,
   input logic [W-1:0] cnt_lo_i,
   input logic [W-1:0] cnt_hi_i,
   input logic [W-1:0] cap_lo_q_i,
   input logic [W-1:0] cap_hi_q_i,
   input logic [1:0]   flag_i
);

   // R12
   mode_change_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (cnt_lo_i == '0 && cnt_hi_i == '0));

   // R12
   stopped_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_i && !clr_i) |=> ($stable(cnt_lo_i) && $stable(cnt_hi_i)));

   // R4
   flag_lo_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_i[0]) |-> (cnt_lo_i == '0));

   // R4
   flag_hi_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_i[1]) |-> (cnt_hi_i == '0));

   // R2
   lo_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!mode_i[1] && !clr_i) |=> (cnt_lo_i == $past(cnt_lo_i) ||
                                  cnt_lo_i == W'($past(cnt_lo_i) + 1'b1) ||
                                  cnt_lo_i == '0));

   // R9
   split_cap_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!mode_i[1] && cap_lo_i) |=> (cap_lo_q_i == $past(cnt_lo_i)));

   // R10
   joined_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i[1] && (cap_lo_i || cap_hi_i)) |=>
         ({cap_hi_q_i, cap_lo_q_i} == {$past(cnt_hi_i), $past(cnt_lo_i)}));

endmodule

bind tmr_dual_capture tmr_dual_capture_chk #(.W(HALF_W)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .mode_i     (mode_q),
   .run_i      (run_q),
   .clr_i      (clr),
   .cap_lo_i   (cap_lo_i),
   .cap_hi_i   (cap_hi_i),
   .cnt_lo_i   (cnt_lo_o),
   .cnt_hi_i   (cnt_hi_o),
   .cap_lo_q_i (cap_lo_o),
   .cap_hi_q_i (cap_hi_o),
   .flag_i     (flag_o)
);

// File: tb/tmr_dual_capture_tb.sv
`timescale 1ns/1ps
module tmr_dual_capture_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       evt_i = 1'b0;
   logic       cap_lo_i = 1'b0;
   logic       cap_hi_i = 1'b0;
   logic [7:0] cnt_lo, cnt_hi, cap_lo, cap_hi;
   logic [1:0] flag;
   logic       irq;

   always #10 clk = ~clk;

   tmr_dual_capture u_dut (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
      .wr_data_i(wr_data), .evt_i(evt_i), .cap_lo_i(cap_lo_i), .cap_hi_i(cap_hi_i),
      .cnt_lo_o(cnt_lo), .cnt_hi_o(cnt_hi), .cap_lo_o(cap_lo), .cap_hi_o(cap_hi),
      .flag_o(flag), .irq_o(irq)
   );

   int    n_tests = 0;
   int    n_fail  = 0;
   string cur_req = "R1";
   bit    chk_en  = 0;
   bit    ev_en   = 0;
   bit    cap_en  = 0;
   logic  ev_man  = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   // Stimulus for events and capture strobes
   always @(negedge clk) begin
      lfsr     <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      evt_i    <= ev_en ? lfsr[0] : ev_man;
      cap_lo_i <= cap_en & lfsr[2] & lfsr[6];
      cap_hi_i <= cap_en & lfsr[4] & lfsr[11];
   end

   // Behavioural reference model
   int m_mode, m_run, m_pre, m_mlo, m_mhi, m_pc, m_lo, m_hi, m_caplo, m_caphi, m_flag;
   int m_s0, m_s1, m_s2;

   always @(posedge clk) begin : model
      int v, src, slo, shi, tick, evc;
      bit clr;
      if (!rst_n) begin
         m_mode = 0; m_run = 0; m_pre = 0; m_mlo = 0; m_mhi = 0; m_pc = 0;
         m_lo = 0; m_hi = 0; m_caplo = 0; m_caphi = 0; m_flag = 0;
         m_s0 = 0; m_s1 = 0; m_s2 = 0;
      end else begin
         clr  = wr_en && wr_addr == 0 && int'(wr_data[1:0]) != m_mode;
         tick = (m_run != 0 && m_pc == m_pre) ? 1 : 0;
         evc  = (m_run != 0 && m_s1 == 1 && m_s2 == 0) ? 1 : 0;
         if (m_mode >= 2) begin
            if (cap_lo_i || cap_hi_i) begin m_caplo = m_lo; m_caphi = m_hi; end
         end else begin
            if (cap_lo_i) m_caplo = m_lo;
            if (cap_hi_i) m_caphi = m_hi;
         end
         if (wr_en && wr_addr == 4) m_flag = m_flag & (3 - int'(wr_data[1:0]));
         if (clr) begin
            m_lo = 0; m_hi = 0; m_pc = 0;
         end else begin
            if (m_mode >= 2) begin
               src = (m_mode == 2) ? tick : evc;
               if (src != 0) begin
                  v = m_hi * 256 + m_lo;
                  if (v == m_mhi * 256 + m_mlo) begin v = 0; m_flag = m_flag | 2; end
                  else v = (v + 1) % 65536;
                  m_lo = v % 256; m_hi = v / 256;
               end
            end else begin
               slo = tick;
               shi = (m_mode == 0) ? tick : evc;
               if (slo != 0) begin
                  if (m_lo == m_mlo) begin m_lo = 0; m_flag = m_flag | 1; end
                  else m_lo = (m_lo + 1) % 256;
               end
               if (shi != 0) begin
                  if (m_hi == m_mhi) begin m_hi = 0; m_flag = m_flag | 2; end
                  else m_hi = (m_hi + 1) % 256;
               end
            end
            if (m_run == 0 || tick != 0) m_pc = 0;
            else m_pc = (m_pc + 1) % 256;
         end
         m_s2 = m_s1; m_s1 = m_s0; m_s0 = int'(evt_i);
         if (wr_en) begin
            case (wr_addr)
               3'd0: begin m_mode = int'(wr_data[1:0]); m_run = int'(wr_data[2]); end
               3'd1: m_pre = int'(wr_data);
               3'd2: m_mlo = int'(wr_data);
               3'd3: m_mhi = int'(wr_data);
               default: ;
            endcase
         end
      end
   end

   // Per-clock comparison, away from the active edge
   always @(negedge clk) begin
      if (chk_en) begin
         chk(int'(cnt_lo) == m_lo,    cur_req, "cnt_lo", cnt_lo, m_lo);
         chk(int'(cnt_hi) == m_hi,    cur_req, "cnt_hi", cnt_hi, m_hi);
         chk(int'(cap_lo) == m_caplo, cur_req, "cap_lo", cap_lo, m_caplo);
         chk(int'(cap_hi) == m_caphi, cur_req, "cap_hi", cap_hi, m_caphi);
         chk(int'(flag) == m_flag,    cur_req, "flag",   flag,   m_flag);
         chk(int'(irq) == (m_flag != 0 ? 1 : 0), cur_req, "irq", irq, (m_flag != 0));
      end
   end

   // Watchdog
   initial begin
      repeat (20000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: act=%0d exp=%0d", 20000, 0);
      finish_run();
   end

   task automatic wr(input int a, input int d);
      wr_en   = 1'b1;
      wr_addr = a[2:0];
      wr_data = d[7:0];
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(cnt_lo == 0 && cnt_hi == 0, "R1", "counts", {cnt_hi, cnt_lo}, 0);
      chk(cap_lo == 0 && cap_hi == 0, "R1", "captures", {cap_hi, cap_lo}, 0);
      chk(flag == 0 && irq == 0, "R1", "flags", {irq, flag}, 0);
      idle(5);
      chk(cnt_lo == 0 && cnt_hi == 0, "R1", "stopped after reset", {cnt_hi, cnt_lo}, 0);
      chk_en = 1;

      // R13 register map, R2 prescaler, R3 split timers, R4 match
      cur_req = "R13";
      wr(1, 2); wr(2, 5); wr(3, 9);
      cur_req = "R2";
      wr(0, 4);
      idle(40);
      cur_req = "R3";
      idle(60);
      cur_req = "R4";
      idle(40);

      // R11 clear racing with set
      cur_req = "R11";
      wr(1, 0); wr(2, 3); wr(3, 6); wr(0, 4);
      repeat (30) wr(4, 3);
      idle(10);
      wr(4, 1);
      idle(5);

      // R5 mixed mode, R6 event synchronizer
      cur_req = "R5";
      wr(1, 1); wr(2, 200); wr(3, 40);
      ev_en = 1;
      wr(0, 5);
      idle(200);
      cur_req = "R6";
      ev_en = 0;
      for (int i = 0; i < 12; i++) begin
         ev_man = 1'b1; idle(1);
         ev_man = 1'b0; idle(1);
      end
      ev_man = 1'b1; idle(6);
      ev_man = 1'b0; idle(6);

      // R7 joined timer with carry
      cur_req = "R7";
      wr(1, 0); wr(2, 8'h23); wr(3, 8'h01);
      wr(0, 6);
      idle(700);

      // R8 joined event counter, prescaler ignored
      cur_req = "R8";
      wr(1, 5); wr(2, 30); wr(3, 0);
      ev_en = 1;
      wr(0, 7);
      idle(300);

      // R10 coherent capture in joined modes
      cur_req = "R10";
      cap_en = 1;
      idle(200);
      wr(1, 0);
      wr(0, 6);
      idle(200);

      // R9 split capture
      cur_req = "R9";
      wr(2, 200); wr(3, 100);
      wr(0, 4);
      idle(200);
      wr(1, 1);
      wr(0, 5);
      idle(200);

      // R12 stop/hold and mode-change clear
      cur_req = "R12";
      cap_en = 0;
      wr(0, 1);
      idle(30);
      wr(0, 5);
      idle(20);
      wr(0, 0);
      idle(10);
      wr(0, 4);
      idle(20);

      chk_en = 0;
      @(negedge clk);
      finish_run();
   end

endmodule